// File: doc/BRIEF.md
# Laser Channel Enable Arbiter

This block decides, once per clock, which drive-current channels of a multi-laser driver are switched on and which of three laser outputs receives the summed current. The channels are one read (bias) channel, four write channels (numbered 2 to 5) and one high-frequency modulation channel. Each channel has a pin-level request and a register-level request. A register bit chooses which of the two sets is used.

After a source is chosen, the block applies the mode rules from the control registers. In skew-check mode, every timing input is folded onto the channel-2 path. In single-input mode, the read channel and channel 5 cannot be on together. Finally, a set of power-save conditions is applied: the global enable pin, a supply-fault flag that can be masked, and an output-select value of zero. All outputs are registered, so each decision appears one clock after its inputs.

All ports are plain level-sensitive controls. There is no data stream, so there is no valid/ready handshake. The register-level fields are expected to come from a register file that updates them only when a serial write completes.

Top module: `ld_chan_arbiter`

## Requirements
- R1: When `reg_src_i` is 0, the channel requests come from the pin inputs. When it is 1, they come from `rd_reg_i`, `wr_reg_i` and `osc_reg_i`. Each register bit is active high.
- R2: The read pin `rd_pin_n_i` is active low. The write pins `wr_pin_i` and the modulation pin `osc_pin_i` are active high. Bit 0 of every write vector is channel 2, and bit 3 is channel 5.
- R3: While `drv_en_i` is low, every channel enable and every bit of `laser_sel_o` is 0 on the following clock, whatever the other inputs are.
- R4: If `supply_fault_i` is high and `mon_dis_i` is low, all outputs are 0 on the following clock. If `mon_dis_i` is high, the fault flag has no effect.
- R5: `laser_sel_o` is one-hot or zero. Output-select value 1 sets bit 0 (first output), value 2 sets bit 1 (second output), value 3 sets bit 2 (short-wavelength output), and value 0 sets no bit.
- R6: In skew-check mode (`skew_mode_i`=1), the channel-2 enable equals the AND of the four selected write requests and the selected modulation request. The enables for channels 3, 4 and 5 and for modulation are 0. The read channel keeps its normal behaviour.
- R7: In single-input mode (`single_in_i`=1), channel 5 wins over the read channel: when channel 5 is on, the read enable is 0.
- R8: In differential mode (`single_in_i`=0), the read channel and channel 5 may both be on at once.
- R9: While `out_sel_i` is 0, every channel enable is 0.
- R10: The outputs are registered and follow the inputs with a latency of one clock. While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| drv_en_i | input | 1 | Global driver enable; low forces power save |
| supply_fault_i | input | 1 | Supply monitor fault flag |
| mon_dis_i | input | 1 | Register bit that masks the supply fault |
| out_sel_i | input | 2 | Laser output select (0 = power save) |
| skew_mode_i | input | 1 | Skew-check mode |
| single_in_i | input | 1 | Channel 5 in single-input mode |
| reg_src_i | input | 1 | 0 = pin requests, 1 = register requests |
| rd_pin_n_i | input | 1 | Read channel pin request, active low |
| wr_pin_i | input | 4 | Write channel pin requests, channels 2..5 |
| osc_pin_i | input | 1 | Modulation pin request |
| rd_reg_i | input | 1 | Read channel register request |
| wr_reg_i | input | 4 | Write channel register requests, channels 2..5 |
| osc_reg_i | input | 1 | Modulation register request |
| rd_en_o | output | 1 | Read channel enable |
| wr_en_o | output | 4 | Write channel enables, channels 2..5 |
| osc_en_o | output | 1 | Modulation channel enable |
| laser_sel_o | output | 3 | One-hot active laser output |

## Verification
The bench targets the corner cases where the rules overlap.

- **Skew-check AND with one input low.** A single input held low in the skew-check AND must pull channel 2 low. A design that ORs the inputs, or that leaves out the modulation input, would still drive channel 2.
- **Skew-check mode together with single-input mode.** Here channel 5 is already forced off, so the read channel must stay on. A design that applies the guard before the skew fold would wrongly drop the read channel.
- **Masked supply fault.** When the fault is masked, the outputs must still follow the requests. A design that ignores the mask bit would go dark.
- **Output select of zero.** With the output select at zero, a design that gated only `laser_sel_o` would leave channel enables asserted.
- **Read pin polarity.** If the read pin polarity were inverted, the read enable would be the wrong value in every pin-sourced vector.

// File: rtl/ld_arb_pkg.sv
package ld_arb_pkg;
  localparam int WR_CH  = 4;
  localparam int LASERS = 3;
  localparam int SEL_W  = $clog2(LASERS + 1);
  localparam int TOP_WR = WR_CH - 1;

  typedef struct packed {
    logic             rd;
    logic [WR_CH-1:0] wr;
    logic             osc;
  } chan_req_t;
endpackage

// File: rtl/ld_arb_src.sv
module ld_arb_src
  import ld_arb_pkg::*;
(
  input  logic             use_reg,
  input  logic             rd_pin_n,
  input  logic [WR_CH-1:0] wr_pin,
  input  logic             osc_pin,
  input  logic             rd_reg,
  input  logic [WR_CH-1:0] wr_reg,
  input  logic             osc_reg,
  output chan_req_t        req
);
  always_comb begin
    req.rd  = use_reg ? rd_reg  : ~rd_pin_n;
    req.osc = use_reg ? osc_reg : osc_pin;
  end

  for (genvar g = 0; g < WR_CH; g++) begin : g_wr
    always_comb req.wr[g] = use_reg ? wr_reg[g] : wr_pin[g];
  end
endmodule

// File: rtl/ld_arb_shape.sv
module ld_arb_shape
  import ld_arb_pkg::*;
(
  input  logic      skew_mode,
  input  logic      single_in,
  input  chan_req_t req_in,
  output chan_req_t req_out
);
  chan_req_t folded;

  // Skew check: all timing inputs ANDed onto the first write path.
  always_comb begin
    folded = req_in;
    if (skew_mode) begin
      folded.wr     = '0;
      folded.wr[0]  = (&req_in.wr) & req_in.osc;
      folded.osc    = 1'b0;
    end
  end

  // Single-input guard: last write channel wins over the read channel.
  always_comb begin
    req_out = folded;
    if (single_in && folded.wr[TOP_WR]) req_out.rd = 1'b0;
  end
endmodule

// File: rtl/ld_arb_gate.sv
module ld_arb_gate
  import ld_arb_pkg::*;
(
  input  logic              drv_en,
  input  logic              supply_fault,
  input  logic              mon_dis,
  input  logic [SEL_W-1:0]  out_sel,
  input  chan_req_t         req_in,
  output chan_req_t         req_out,
  output logic [LASERS-1:0] laser_sel
);
  logic power_save;

  always_comb begin
    power_save = !drv_en || (supply_fault && !mon_dis) || (out_sel == '0);
    req_out    = power_save ? '0 : req_in;
  end

  for (genvar g = 0; g < LASERS; g++) begin : g_sel
    always_comb laser_sel[g] = !power_save && (out_sel == SEL_W'(g + 1));
  end
endmodule

// File: rtl/ld_chan_arbiter.sv
module ld_chan_arbiter
  import ld_arb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drv_en_i,
  input  logic              supply_fault_i,
  input  logic              mon_dis_i,
  input  logic [SEL_W-1:0]  out_sel_i,
  input  logic              skew_mode_i,
  input  logic              single_in_i,
  input  logic              reg_src_i,
  input  logic              rd_pin_n_i,
  input  logic [WR_CH-1:0]  wr_pin_i,
  input  logic              osc_pin_i,
  input  logic              rd_reg_i,
  input  logic [WR_CH-1:0]  wr_reg_i,
  input  logic              osc_reg_i,
  output logic              rd_en_o,
  output logic [WR_CH-1:0]  wr_en_o,
  output logic              osc_en_o,
  output logic [LASERS-1:0] laser_sel_o
);
  chan_req_t           req_src, req_shaped, req_final;
  logic [LASERS-1:0]   sel_next;
  chan_req_t           req_q;
  logic [LASERS-1:0]   sel_q;

  ld_arb_src u_src (
    .use_reg (reg_src_i),
    .rd_pin_n(rd_pin_n_i),
    .wr_pin  (wr_pin_i),
    .osc_pin (osc_pin_i),
    .rd_reg  (rd_reg_i),
    .wr_reg  (wr_reg_i),
    .osc_reg (osc_reg_i),
    .req     (req_src)
  );

  ld_arb_shape u_shape (
    .skew_mode(skew_mode_i),
    .single_in(single_in_i),
    .req_in   (req_src),
    .req_out  (req_shaped)
  );

  ld_arb_gate u_gate (
    .drv_en      (drv_en_i),
    .supply_fault(supply_fault_i),
    .mon_dis     (mon_dis_i),
    .out_sel     (out_sel_i),
    .req_in      (req_shaped),
    .req_out     (req_final),
    .laser_sel   (sel_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      sel_q <= '0;
    end else begin
      req_q <= req_final;
      sel_q <= sel_next;
    end
  end

  assign rd_en_o     = req_q.rd;
  assign wr_en_o     = req_q.wr;
  assign osc_en_o    = req_q.osc;
  assign laser_sel_o = sel_q;
endmodule

// File: rtl/ld_chan_arbiter_chk.sv
module ld_chan_arbiter_chk
  import ld_arb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              drv_en_i,
  input logic              supply_fault_i,
  input logic              mon_dis_i,
  input logic [SEL_W-1:0]  out_sel_i,
  input logic              skew_mode_i,
  input logic              single_in_i,
  input logic              rd_en_o,
  input logic [WR_CH-1:0]  wr_en_o,
  input logic              osc_en_o,
  input logic [LASERS-1:0] laser_sel_o
);
  logic any_on;
  assign any_on = rd_en_o || (|wr_en_o) || osc_en_o || (|laser_sel_o);

  AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(drv_en_i) |-> !any_on); // R3
  AST_FAULT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $past(supply_fault_i && !mon_dis_i) |-> !any_on); // R4
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(laser_sel_o)); // R5
  AST_SKEW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(skew_mode_i) |-> (wr_en_o[WR_CH-1:1] == '0) && !osc_en_o); // R6
  AST_SINGLE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $past(single_in_i) |-> !(rd_en_o && wr_en_o[TOP_WR])); // R7
  AST_IDLE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(out_sel_i) == '0) |-> !any_on); // R9
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> !any_on); // R10
endmodule

bind ld_chan_arbiter ld_chan_arbiter_chk u_chk (.*);

// File: tb/ld_chan_arbiter_bench.sv
module ld_chan_arbiter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic drv_en, fault, mon_dis, skew, single, src;
  logic [1:0] osel;
  logic rd_n, osc_p, rd_r, osc_r;
  logic [3:0] wr_p, wr_r;
  logic rd_en, osc_en;
  logic [3:0] wr_en;
  logic [2:0] lsel;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ld_chan_arbiter u_ld_chan_arbiter (
    .clk(clk), .rst_n(rst_n), .drv_en_i(drv_en), .supply_fault_i(fault),
    .mon_dis_i(mon_dis), .out_sel_i(osel), .skew_mode_i(skew),
    .single_in_i(single), .reg_src_i(src), .rd_pin_n_i(rd_n),
    .wr_pin_i(wr_p), .osc_pin_i(osc_p), .rd_reg_i(rd_r), .wr_reg_i(wr_r),
    .osc_reg_i(osc_r), .rd_en_o(rd_en), .wr_en_o(wr_en),
    .osc_en_o(osc_en), .laser_sel_o(lsel)
  );

  // Expected {rd, wr[3:0], osc, laser[2:0]} from the requirements.
  function automatic logic [8:0] model();
    logic r, o;
    logic [3:0] w;
    logic [2:0] l;
    r = src ? rd_r : ~rd_n;              // R1, R2
    w = src ? wr_r : wr_p;
    o = src ? osc_r : osc_p;
    if (skew) begin                      // R6
      w = {3'b000, (&w) & o};
      o = 1'b0;
    end
    if (single && w[3]) r = 1'b0;        // R7
    if (!drv_en || (fault && !mon_dis) || osel == 2'd0) return '0; // R3 R4 R9
    l = 3'b001 << (osel - 2'd1);         // R5
    return {r, w, o, l};
  endfunction

  task automatic check(input logic [8:0] exp, input string req);
    logic [8:0] act;
    act = {rd_en, wr_en, osc_en, lsel};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Drive at a falling edge, compare at the next falling edge.
  task automatic apply(input string req);
    logic [8:0] exp;
    exp = model();
    @(negedge clk);
    check(exp, req);
  endtask

  task automatic base();
    drv_en = 1; fault = 0; mon_dis = 0; skew = 0; single = 0; src = 0;
    osel = 2'd1; rd_n = 1; wr_p = 0; osc_p = 0; rd_r = 0; wr_r = 0; osc_r = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    base();
    drv_en = 1; rd_n = 0; wr_p = 4'hF;
    repeat (3) @(negedge clk);
    check(9'd0, "R10 reset");
    rst_n = 1'b1;
    base(); @(negedge clk);

    // R2: read pin active low, writes active high
    base(); rd_n = 0; wr_p = 4'b0101; apply("R2 pin polarity");
    base(); rd_n = 1; wr_p = 4'b0010; osc_p = 1; apply("R2 read pin high");
    // R1: register source ignores pins
    base(); src = 1; rd_n = 0; wr_p = 4'hF; rd_r = 0; wr_r = 4'b1000; osc_r = 1;
    apply("R1 register source");
    base(); src = 0; rd_r = 1; wr_r = 4'hF; apply("R1 pin source");
    // R3
    base(); drv_en = 0; rd_n = 0; wr_p = 4'hF; osc_p = 1; apply("R3 global off");
    // R4
    base(); fault = 1; rd_n = 0; wr_p = 4'h3; apply("R4 fault off");
    base(); fault = 1; mon_dis = 1; rd_n = 0; wr_p = 4'h3; apply("R4 fault masked");
    // R5
    base(); osel = 2'd2; rd_n = 0; apply("R5 second output");
    base(); osel = 2'd3; rd_n = 0; apply("R5 third output");
    // R9
    base(); osel = 2'd0; rd_n = 0; wr_p = 4'hF; osc_p = 1; apply("R9 select zero");
    // R6
    base(); skew = 1; wr_p = 4'hF; osc_p = 1; apply("R6 skew all high");
    base(); skew = 1; wr_p = 4'hF; osc_p = 0; apply("R6 skew osc low");
    base(); skew = 1; wr_p = 4'b1011; osc_p = 1; rd_n = 0; apply("R6 skew one low");
    base(); skew = 1; single = 1; wr_p = 4'hF; osc_p = 1; rd_n = 0;
    apply("R6 R7 skew with single");
    // R7 / R8
    base(); single = 1; rd_n = 0; wr_p = 4'b1000; apply("R7 single guard");
    base(); single = 1; rd_n = 0; wr_p = 4'b0001; apply("R7 read kept");
    base(); single = 0; rd_n = 0; wr_p = 4'b1000; apply("R8 differential add");
    // R10: one-clock latency
    base(); rd_n = 0; @(negedge clk);
    rd_n = 1; wr_p = 4'b0100;
    #1 check(9'b1_0000_0_001, "R10 latency hold");
    @(negedge clk); check(model(), "R10 latency update");

    for (int i = 0; i < 3000; i++) begin
      drv_en = ($urandom % 8) != 0; fault = ($urandom % 6) == 0;
      mon_dis = $urandom; skew = ($urandom % 4) == 0; single = $urandom;
      src = $urandom; osel = $urandom; rd_n = $urandom; wr_p = $urandom;
      osc_p = $urandom; rd_r = $urandom; wr_r = $urandom; osc_r = $urandom;
      if ($urandom % 4 == 0) begin wr_p = 4'hF; wr_r = 4'hF; end
      apply("R1 random");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule